// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block holds the architectural registers of a small processor datapath. Each register is picked by a 4-bit identifier, and the identifier is the address. Two read ports and one write port are independent. All three can act in the same cycle, and each has its own identifier and data lines.

The read ports are combinational: a read output follows its identifier with no clock edge in between. The write port changes the stored word only on a rising clock edge. The identifier value 15 is reserved as a "none" code. On a read port it gives a zero word. On the write port it blocks the update. Identifiers 0 to 14 map to real registers of parameterised width. There is no bypass: a value written in a cycle shows up on a read port only after the edge that stores it. A synchronous reset clears every register to zero.

Top module: `regfile_2r1w`

## Requirements
- R1: After a synchronous reset (rst high at a rising edge), every register 0..14 reads as zero.
- R2: A read port with identifier 0..14 outputs the word currently stored in that register, combinationally and without waiting for a clock edge.
- R3: A read port whose identifier is 15 (all ones) outputs zero.
- R4: A write with identifier 0..14 and wr_en high stores wr_data into that register at the rising clock edge.
- R5: A write with identifier 15 changes no register.
- R6: While wr_en is low, no register changes.
- R7: A register written in a cycle still reads its old value on either port before that edge and reads the new value after it, so there is no bypass.
- R8: The two read ports are independent. Both may address the same register or different registers in the same cycle while a write goes to a third.
- R9: A write changes only the addressed register and leaves the other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_id | input | 4 | Read port A register identifier (15 = none) |
| rd_a_data | output | WIDTH | Read port A data |
| rd_b_id | input | 4 | Read port B register identifier (15 = none) |
| rd_b_data | output | WIDTH | Read port B data |
| wr_en | input | 1 | Write request |
| wr_id | input | 4 | Write port register identifier (15 = none) |
| wr_data | input | WIDTH | Write data |

## Verification
Every register is first loaded with a value derived from its index, for example a distinct pattern per register. A full sweep of both read identifiers then shows that the address decode reaches the right register on each port and that identifier 15 gives zero. The next step is a write to every identifier, including 15, with the register file read back in full. This separates a write that hits the wrong register or leaks into others from a correct one. A separate pass keeps wr_en low while driving writes. Same-cycle write-and-read patterns are sampled both before and after the edge to show that there is no bypass.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    localparam int ID_W    = 4;
    localparam int NUM_IDS = 1 << ID_W;
    localparam int NUM_REG = NUM_IDS - 1;
    localparam logic [ID_W-1:0] ID_NONE = '1;

    typedef logic [ID_W-1:0] reg_id_t;

    function automatic logic id_is_real(input reg_id_t id);
        return id != ID_NONE;
    endfunction
endpackage

// File: rtl/regfile_wr_decode.sv
module regfile_wr_decode
    import regfile_pkg::*;
#(
    parameter int N = NUM_REG
) (
    input  logic          wr_en,
    input  reg_id_t       wr_id,
    output logic [N-1:0]  wr_sel
);
    always_comb begin
        wr_sel = '0;
        for (int i = 0; i < N; i++) begin
            wr_sel[i] = wr_en && id_is_real(wr_id) && (wr_id == reg_id_t'(i));
        end
    end

    always_comb begin
        assert ($onehot0(wr_sel)) else $error("AST_WR_ONEHOT");                  // R9
        if (!wr_en) assert (wr_sel == '0) else $error("AST_WR_IDLE");            // R6
        if (wr_id == ID_NONE) assert (wr_sel == '0) else $error("AST_WR_NONE");  // R5
    end
endmodule

// File: rtl/regfile_read_port.sv
module regfile_read_port
    import regfile_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int N     = NUM_REG
) (
    input  logic [N-1:0][WIDTH-1:0] regs,
    input  reg_id_t                 rd_id,
    output logic [WIDTH-1:0]        rd_data
);
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_id == reg_id_t'(i)) rd_data = regs[i];
        end
    end

    always_comb begin
        if (rd_id == ID_NONE) assert (rd_data == '0) else $error("AST_RD_NONE_ZERO"); // R3
    end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
    import regfile_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       rd_a_id,
    output logic [WIDTH-1:0] rd_a_data,
    input  logic [3:0]       rd_b_id,
    output logic [WIDTH-1:0] rd_b_data,
    input  logic             wr_en,
    input  logic [3:0]       wr_id,
    input  logic [WIDTH-1:0] wr_data
);
    typedef struct packed {
        logic [NUM_REG-1:0][WIDTH-1:0] regs;
    } state_t;

    state_t        st_d, st_q;
    logic [NUM_REG-1:0] wr_sel;

    regfile_wr_decode #(.N(NUM_REG)) u_dec (
        .wr_en  (wr_en),
        .wr_id  (wr_id),
        .wr_sel (wr_sel)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.regs = '0;
        end else begin
            for (int i = 0; i < NUM_REG; i++) begin
                if (wr_sel[i]) st_d.regs[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    regfile_read_port #(.WIDTH(WIDTH), .N(NUM_REG)) u_rd_a (
        .regs    (st_q.regs),
        .rd_id   (rd_a_id),
        .rd_data (rd_a_data)
    );

    regfile_read_port #(.WIDTH(WIDTH), .N(NUM_REG)) u_rd_b (
        .regs    (st_q.regs),
        .rd_id   (rd_b_id),
        .rd_data (rd_b_data)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (st_q.regs == '0)) else $error("AST_RESET_CLEARS");     // R1
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_id != ID_NONE) |=> (st_q.regs[$past(wr_id)] == $past(wr_data)))
        else $error("AST_WRITE_LANDS");                                          // R4
    AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || wr_id == ID_NONE) |=> $stable(st_q.regs))
        else $error("AST_NO_WRITE_STABLE");                                      // R5
    AST_PORT_A_READ: assert property (@(posedge clk)
        (rd_a_id != ID_NONE) |-> (rd_a_data == st_q.regs[rd_a_id]))
        else $error("AST_PORT_A_READ");                                          // R2
    AST_PORT_B_NONE: assert property (@(posedge clk)
        (rd_b_id == ID_NONE) |-> (rd_b_data == '0))
        else $error("AST_PORT_B_NONE");                                          // R3
endmodule

// File: tb/regfile_2r1w_bench.sv
`timescale 1ns/1ps
module regfile_2r1w_bench;
    localparam int W = 16;
    logic clk = 0;
    logic rst;
    logic [3:0] rd_a_id, rd_b_id, wr_id;
    logic [W-1:0] rd_a_data, rd_b_data, wr_data;
    logic wr_en;
    int n_cmp = 0, n_bad = 0;
    logic [W-1:0] model [15];

    always #5 clk = ~clk;

    regfile_2r1w #(.WIDTH(W)) u_regfile_2r1w (
        .clk, .rst, .rd_a_id, .rd_a_data, .rd_b_id, .rd_b_data,
        .wr_en, .wr_id, .wr_data
    );

    function automatic logic [W-1:0] pat(input int i, input int s);
        return W'((i * 16'h1357) ^ (s * 16'h0F0F) ^ 16'hA5A5 ^ i);
    endfunction

    function automatic logic [W-1:0] expect_rd(input logic [3:0] id);
        return (id == 4'hF) ? '0 : model[id];
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); #2;
    endtask

    task automatic sweep_all(input string req);
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                rd_a_id = 4'(a); rd_b_id = 4'(b); #1;
                check(req, rd_a_data, expect_rd(4'(a)));
                check(req, rd_b_data, expect_rd(4'(b)));
            end
        end
    endtask

    initial begin
        #150000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1; wr_en = 0; wr_id = 0; wr_data = 0; rd_a_id = 0; rd_b_id = 0;
        for (int i = 0; i < 15; i++) model[i] = '0;
        // preload garbage then reset
        @(negedge clk); rst = 0; wr_en = 1;
        for (int i = 0; i < 15; i++) begin wr_id = 4'(i); wr_data = 16'hFFFF; tick(); end
        wr_en = 0; rst = 1; tick(); rst = 0;
        sweep_all("R1");

        // fill every register: R4, R2, R3, R8
        for (int s = 1; s < 3; s++) begin
            wr_en = 1;
            for (int i = 0; i < 15; i++) begin
                wr_id = 4'(i); wr_data = pat(i, s); tick(); model[i] = pat(i, s);
            end
            wr_en = 0;
            sweep_all("R4");
            sweep_all("R8");
        end

        // write to id 15: R5
        wr_en = 1; wr_id = 4'hF; wr_data = 16'h1234; tick(); wr_en = 0;
        sweep_all("R5");

        // wr_en low: R6
        for (int i = 0; i < 15; i++) begin wr_id = 4'(i); wr_data = 16'hBEEF; tick(); end
        sweep_all("R6");

        // single write isolation: R9
        for (int i = 0; i < 15; i++) begin
            wr_en = 1; wr_id = 4'(i); wr_data = pat(i, 7); tick(); wr_en = 0;
            model[i] = pat(i, 7);
            for (int k = 0; k < 15; k++) begin
                rd_a_id = 4'(k); #1; check("R9", rd_a_data, model[k]);
            end
        end

        // no bypass: R7, plus simultaneous dual reads R8
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            wr_en = 1; wr_id = 4'(i); wr_data = pat(i, 9);
            rd_a_id = 4'(i); rd_b_id = 4'(i); #1;
            check("R7", rd_a_data, model[i]);
            check("R7", rd_b_data, model[i]);
            tick(); wr_en = 0; model[i] = pat(i, 9);
            check("R7", rd_a_data, model[i]);
            check("R7", rd_b_data, model[i]);
            rd_a_id = 4'(i); rd_b_id = 4'hF; #1;
            check("R3", rd_b_data, '0);
        end

        // combinational read with no edge: R2
        @(negedge clk);
        for (int i = 0; i < 15; i++) begin
            rd_a_id = 4'(i); #0.5; check("R2", rd_a_data, model[i]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule